// File: doc/BRIEF.md
# Loadable Up/Down Step Counter

A fully synchronous counter, 9 bits wide by default, that moves by an asymmetric step on each enabled clock. It adds three when the direction input selects up and subtracts five when it selects down. The value wraps modulo 2^W. A parallel load presets the count, and a synchronous reset clears it. Every state change happens on the rising clock edge.

Alongside the count the block registers three flags: an even-parity bit, a carry flag and a borrow flag. The parity bit makes the count bits plus the parity bit hold an even number of ones. Carry marks an up step that wrapped past the top of the range. Borrow marks a down step that went below zero.

The parity is computed ahead from the next-state value, through a balanced XOR tree, so it never lags the count on display. Both flags describe the step just taken. They are valid for exactly the one cycle that follows that step.

Top module: `step_counter`

## Requirements
- R1: When `rst_i` is high at a rising edge, the next cycle shows `cnt_o`=0, `par_o`=0, `carry_o`=0 and `borrow_o`=0.
- R2: When `load_i` is high and `rst_i` is low at an edge, `cnt_o` takes `load_val_i` and both flags clear, whatever `en_i` and `dir_i` are.
- R3: With `en_i`=1, `dir_i`=1 (up) and no load or reset, `cnt_o` becomes (`cnt_o`+3) mod 512.
- R4: With `en_i`=1, `dir_i`=0 (down) and no load or reset, `cnt_o` becomes (`cnt_o`-5) mod 512.
- R5: After an up step, `carry_o` is 1 exactly when the old count plus 3 exceeded 511, and `borrow_o` is 0.
- R6: After a down step, `borrow_o` is 1 exactly when the old count was below 5, and `carry_o` is 0.
- R7: `par_o` always equals the XOR of all bits of the `cnt_o` value shown in the same cycle, so `{cnt_o, par_o}` holds an even number of ones.
- R8: With `en_i`=0 and no load or reset, `cnt_o` holds its value and both flags are 0 in the next cycle.
- R9: Reset takes priority over load. With both high, the count clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Parallel load strobe |
| load_val_i | input | W (9) | Value to preset |
| en_i | input | 1 | Count enable |
| dir_i | input | 1 | Direction: 1 counts up by 3, 0 counts down by 5 |
| cnt_o | output | W (9) | Current count |
| par_o | output | 1 | Even-parity bit over `cnt_o` |
| carry_o | output | 1 | Previous step wrapped upward |
| borrow_o | output | 1 | Previous step wrapped downward |

## Verification
The bench presets every one of the 512 start values and takes one up step, one down step and one hold from each. This covers each wrap boundary: 509 through 511 for carry, and 0 through 4 for borrow.

A design with an off-by-one wrap test would raise carry at 508 or miss it at 509. A design that compared against the wrong step size would flag borrow on the wrong starting values.

A design whose parity came from the old count would show the wrong parity bit right after many steps. A design that held the flags through idle cycles would be caught by the hold checks. A long run of up steps checks that carry falls again on the first step that does not wrap.

// File: rtl/step_ctr_pkg.sv
package step_ctr_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

endpackage

// File: rtl/ctr_step_unit.sv
module ctr_step_unit #(
    parameter int W    = 9,
    parameter int STEP = 3,
    parameter bit UP   = 1'b1
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);

    localparam logic [W:0] STEP_EXT = (W+1)'(STEP);

    logic [W:0] ext;

    generate
        if (UP) begin : g_inc
            // The extra top bit is the carry out of the W-bit range.
            assign ext = {1'b0, cur_i} + STEP_EXT;
        end else begin : g_dec
            // The extra top bit goes high when the subtraction goes negative.
            assign ext = {1'b0, cur_i} - STEP_EXT;
        end
    endgenerate

    assign nxt_o  = ext[W-1:0];
    assign wrap_o = ext[W];

endmodule

// File: rtl/ctr_parity_tree.sv
module ctr_parity_tree #(
    parameter int W = 9
) (
    input  logic [W-1:0] val_i,
    output logic         par_o
);

    localparam int LVL = (W > 1) ? $clog2(W) : 1;
    localparam int N   = 1 << LVL;

    logic [N-1:0] lvl [LVL+1];

    // Leaf level: the value, padded with zeros to a power of two.
    assign lvl[0] = N'(val_i);

    generate
        for (genvar l = 0; l < LVL; l++) begin : g_lvl
            for (genvar i = 0; i < (N >> (l+1)); i++) begin : g_node
                assign lvl[l+1][i] = lvl[l][2*i] ^ lvl[l][2*i+1];
            end
            // Upper bits of each level are unused; tie them off.
            assign lvl[l+1][N-1:(N >> (l+1))] = '0;
        end
    endgenerate

    assign par_o = lvl[LVL][0];

endmodule

// File: rtl/step_counter.sv
module step_counter
    import step_ctr_pkg::*;
#(
    parameter int W       = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         en_i,
    input  logic         dir_i,
    output logic [W-1:0] cnt_o,
    output logic         par_o,
    output logic         carry_o,
    output logic         borrow_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         par;
        logic         carry;
        logic         borrow;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] up_val, dn_val, cnt_nxt;
    logic         up_wrap, dn_wrap, par_nxt;
    dir_e         dir;

    assign dir = dir_e'(dir_i);

    ctr_step_unit #(.W(W), .STEP(UP_STEP), .UP(1'b1)) up_i (
        .cur_i  (state_q.cnt),
        .nxt_o  (up_val),
        .wrap_o (up_wrap)
    );

    ctr_step_unit #(.W(W), .STEP(DN_STEP), .UP(1'b0)) dn_i (
        .cur_i  (state_q.cnt),
        .nxt_o  (dn_val),
        .wrap_o (dn_wrap)
    );

    // Pick the next count: reset, then load, then count, then hold.
    always_comb begin
        if (rst_i) begin
            cnt_nxt = '0;
        end else if (load_i) begin
            cnt_nxt = load_val_i;
        end else if (en_i) begin
            cnt_nxt = (dir == DIR_UP) ? up_val : dn_val;
        end else begin
            cnt_nxt = state_q.cnt;
        end
    end

    // Parity is taken from the next count, so it is registered with it.
    ctr_parity_tree #(.W(W)) par_i (
        .val_i (cnt_nxt),
        .par_o (par_nxt)
    );

    always_comb begin
        state_d        = state_q;
        state_d.cnt    = cnt_nxt;
        state_d.par    = par_nxt;
        state_d.carry  = 1'b0;
        state_d.borrow = 1'b0;
        if (!rst_i && !load_i && en_i) begin
            if (dir == DIR_UP) begin
                state_d.carry = up_wrap;
            end else begin
                state_d.borrow = dn_wrap;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign cnt_o    = state_q.cnt;
    assign par_o    = state_q.par;
    assign carry_o  = state_q.carry;
    assign borrow_o = state_q.borrow;

endmodule

// File: rtl/step_counter_chk.sv
module step_counter_chk #(
    parameter int W       = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         load_i,
    input logic [W-1:0] load_val_i,
    input logic         en_i,
    input logic         dir_i,
    input logic [W-1:0] cnt_o,
    input logic         par_o,
    input logic         carry_o,
    input logic         borrow_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (cnt_o == '0) && !par_o && !carry_o && !borrow_o);

    // R2
    load_preset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_o == $past(load_val_i)) && !carry_o && !borrow_o);

    // R3
    up_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && dir_i) |=> cnt_o == W'($past(cnt_o) + W'(UP_STEP)));

    // R4
    down_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && !dir_i) |=> cnt_o == W'($past(cnt_o) - W'(DN_STEP)));

    // R5
    carry_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && dir_i) |=>
            (carry_o == ($past(cnt_o) > W'((1 << W) - 1 - UP_STEP))) && !borrow_o);

    // R6
    borrow_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && !dir_i) |=>
            (borrow_o == ($past(cnt_o) < W'(DN_STEP))) && !carry_o);

    // R7
    parity_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (^{cnt_o, par_o}) == 1'b0);

    // R8
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !en_i) |=> $stable(cnt_o) && !carry_o && !borrow_o);

endmodule

bind step_counter step_counter_chk #(.W(W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .en_i       (en_i),
    .dir_i      (dir_i),
    .cnt_o      (cnt_o),
    .par_o      (par_o),
    .carry_o    (carry_o),
    .borrow_o   (borrow_o)
);

// File: tb/step_counter_tb_top.sv
module step_counter_tb_top;

    localparam int W   = 9;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] load_val_i = '0;
    logic         en_i = 1'b0;
    logic         dir_i = 1'b0;
    logic [W-1:0] cnt_o;
    logic         par_o, carry_o, borrow_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    step_counter #(.W(W), .UP_STEP(3), .DN_STEP(5)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .en_i       (en_i),
        .dir_i      (dir_i),
        .cnt_o      (cnt_o),
        .par_o      (par_o),
        .carry_o    (carry_o),
        .borrow_o   (borrow_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change at a falling edge; the design registers them at the
    // next rising edge; outputs are sampled at the falling edge after that.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int xor_bits(input int v);
        int p = 0;
        for (int b = 0; b < W; b++) p ^= (v >> b) & 1;
        return p;
    endfunction

    task automatic check_all(input string req, input int c, input int cy, input int bw);
        check({req, " count"}, int'(cnt_o), c);
        check({req, " carry"}, int'(carry_o), cy);
        check({req, " borrow"}, int'(borrow_o), bw);
        check("R7 parity", int'(par_o), xor_bits(c));
    endtask

    task automatic preset(input int v);
        load_i = 1'b1; load_val_i = W'(v); en_i = 1'b1; dir_i = v[0];
        tick();
        load_i = 1'b0;
    endtask

    initial begin
        int c;
        @(negedge clk);
        // R1: reset state
        rst_i = 1'b1;
        tick();
        check_all("R1", 0, 0, 0);
        // R9: reset wins over load
        load_i = 1'b1; load_val_i = 9'd300; en_i = 1'b1;
        tick();
        check_all("R9", 0, 0, 0);
        rst_i = 1'b0; load_i = 1'b0;

        for (int v = 0; v < MOD; v++) begin
            // R2: load with enable high still presets and clears flags
            preset(v);
            check_all("R2", v, 0, 0);
            en_i = 1'b1; dir_i = 1'b1;
            tick();
            // R3 and R5
            check_all("R3/R5 up", (v + 3) % MOD, (v + 3 >= MOD) ? 1 : 0, 0);
            preset(v);
            en_i = 1'b1; dir_i = 1'b0;
            tick();
            // R4 and R6
            check_all("R4/R6 down", (v + MOD - 5) % MOD, 0, (v < 5) ? 1 : 0);
            c = (v + MOD - 5) % MOD;
            en_i = 1'b0; dir_i = 1'b1;
            tick();
            // R8: idle holds, flags drop
            check_all("R8 hold", c, 0, 0);
        end

        // R5: long up run from near the top; carry only on wrapping steps
        preset(500);
        c = 500;
        en_i = 1'b1; dir_i = 1'b1;
        for (int k = 0; k < 200; k++) begin
            tick();
            check_all("R5 run", (c + 3) % MOD, (c + 3 >= MOD) ? 1 : 0, 0);
            c = (c + 3) % MOD;
        end
        // R6: long down run; borrow only on wrapping steps
        dir_i = 1'b0;
        for (int k = 0; k < 200; k++) begin
            tick();
            check_all("R6 run", (c + MOD - 5) % MOD, 0, (c < 5) ? 1 : 0);
            c = (c + MOD - 5) % MOD;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule